// File: doc/BRIEF.md
# Boot Mode Loader

This block runs straight out of reset and loads the chip's fundamental operating modes from a slow serial source, such as a small serial memory or a few gates of glue logic. It produces its own slow serial clock by dividing the system clock by 256. It takes one data bit per slow period, lowest position first, until it has all 256 positions of the stream. It then publishes the decoded mode fields to the rest of the chip and raises a done flag.

Fields that the chip acts on are decoded into ready-to-use values: the bus transmit pattern code, the core-to-bus clock multiplier, byte order, non-block write protocol, timer interrupt masking, bus width, output drive strength in percent, the write address-to-data gap and the slow-multiply choice. Any position or code that is reserved raises a sticky configuration error flag, which is reported along with done. After done the serial clock stops. The outputs then stay frozen until the next reset.

Top module: `boot_mode_loader`

## Requirements
- R1: `sclkOut` has a period of 256 system clocks with 128 clocks high and 128 low, starting low; it is low during reset.
- R2: The stream is 256 bits long and arrives lowest position first; one bit of `serData` is captured per `sclkOut` period, at the system clock edge where `sclkOut` rises.
- R3: Stream bits 4..1 (bit 4 most significant) appear unchanged on `xferPattern`; stream bits 7..5 (bit 7 most significant) hold a code c and `clkRatio` shows c+2.
- R4: Stream bit 8 drives `bigEndian` (1 = big), bit 11 drives `timerIntOff`, bit 12 drives `narrowBus` (1 = 32-bit bus), bit 19 drives `slowMul`.
- R5: Stream bits 10..9 (bit 10 most significant) appear on `wrMode` (00 legacy, 10 pipelined, 11 re-issue); stream bits 17..15 (bit 17 most significant) appear on `wrDataDelay`.
- R6: Stream bits 14..13 (bit 14 most significant) map to `drivePct`: 10 gives 100, 11 gives 83, 00 gives 67, 01 gives 50.
- R7: `cfgDone` rises at the edge that captures stream bit 255. Until then every output holds its reset value: zero everywhere, except `clkRatio` = 2 and `drivePct` = 100.
- R8: When done rises, `cfgError` is 1 if any of stream bits 0, 18 or 20..255 is 1, or the pattern code exceeds 8, or the ratio code is 7, or the write mode code is 01; otherwise it is 0.
- R9: After done, `sclkOut` stays low, `serData` is ignored, and all outputs including `cfgError` stay unchanged until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serData | input | 1 | Serial mode data from the external source |
| sclkOut | output | 1 | Divided serial clock to the source |
| xferPattern | output | 4 | Bus transmit data pattern code |
| clkRatio | output | 4 | Core-to-bus clock multiplier (2..8) |
| bigEndian | output | 1 | 1 = big-endian byte order |
| wrMode | output | 2 | Non-block write protocol code |
| timerIntOff | output | 1 | 1 = timer interrupt masked on interrupt line 5 |
| narrowBus | output | 1 | 1 = 32-bit system bus |
| drivePct | output | 7 | Output drive strength in percent |
| wrDataDelay | output | 3 | Bus cycles between write address and write data |
| slowMul | output | 1 | 1 = fast multiply disabled |
| cfgError | output | 1 | Sticky flag: a reserved bit or code was seen |
| cfgDone | output | 1 | Mode vector loaded and valid |

## Verification
The bench aims at the places where an off-by-one in the capture logic would show up. A reserved bit in the very last position, 255, must still raise the error. A loader that closed the vector one bit early, or sampled on the falling half of the serial clock, would miss it or shift every field by one position. Each of the four drive-strength codes is loaded, so a straight binary map would show wrong percentages. The three reserved codes are tested one at a time, so an error term that is left out shows up alone. After done the bench toggles the data line while watching the serial clock, which catches a loader that keeps running or that lets late bits leak into the decoded fields.

// File: rtl/bml_pkg.sv
package bml_pkg;

  // number of leading stream positions that are kept as captured bits
  localparam int CAP_W = 20;

  // positions the decode depends on
  localparam int POS_PAT     = 1;
  localparam int POS_RATIO   = 5;
  localparam int POS_ENDIAN  = 8;
  localparam int POS_WRMODE  = 9;
  localparam int POS_TIMER   = 11;
  localparam int POS_WIDTH   = 12;
  localparam int POS_DRIVE   = 13;
  localparam int POS_DELAY   = 15;
  localparam int POS_RSVD_LO = 18;
  localparam int POS_SLOWMUL = 19;
  localparam int POS_RSVD_HI = 20;

  localparam int PAT_MAX_OK  = 8;

  typedef enum logic [1:0] {
    WR_LEGACY    = 2'b00,
    WR_BAD       = 2'b01,
    WR_PIPELINED = 2'b10,
    WR_REISSUE   = 2'b11
  } wr_mode_e;

  // control-to-datapath strobes
  typedef struct packed {
    logic sample;
    logic commit;
  } ld_strobe_t;

  typedef struct packed {
    logic [3:0] xferPattern;
    logic [3:0] clkRatio;
    logic       bigEndian;
    wr_mode_e   wrMode;
    logic       timerIntOff;
    logic       narrowBus;
    logic [6:0] drivePct;
    logic [2:0] wrDataDelay;
    logic       slowMul;
  } boot_mode_t;

  localparam boot_mode_t MODE_DEFAULT = '{
    xferPattern: 4'd0,
    clkRatio:    4'd2,
    bigEndian:   1'b0,
    wrMode:      WR_LEGACY,
    timerIntOff: 1'b0,
    narrowBus:   1'b0,
    drivePct:    7'd100,
    wrDataDelay: 3'd0,
    slowMul:     1'b0
  };

endpackage

// File: rtl/bml_ctrl.sv
module bml_ctrl
  import bml_pkg::*;
#(
  parameter int DIV        = 256,
  parameter int STREAM_LEN = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  output ld_strobe_t                    strb,
  output logic [$clog2(STREAM_LEN)-1:0] bitIdx,
  output logic                          sclkOut
);

  localparam int DIV_W = $clog2(DIV);
  localparam int IDX_W = $clog2(STREAM_LEN);
  localparam logic [DIV_W-1:0] HALF      = DIV_W'(DIV / 2);
  localparam logic [DIV_W-1:0] PRE_RISE  = DIV_W'(DIV / 2 - 1);
  localparam logic [DIV_W-1:0] LAST_TICK = DIV_W'(DIV - 1);
  localparam logic [IDX_W-1:0] LAST_BIT  = IDX_W'(STREAM_LEN - 1);

  logic [DIV_W-1:0] divCnt;
  logic             running;
  logic             sampleNow;

  // capture coincides with the edge that lifts the serial clock
  assign sampleNow   = running && (divCnt == PRE_RISE);
  assign strb.sample = sampleNow;
  assign strb.commit = sampleNow && (bitIdx == LAST_BIT);
  assign sclkOut     = running && (divCnt >= HALF);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bitIdx  <= '0;
      running <= 1'b1;
    end else if (running) begin
      divCnt <= (divCnt == LAST_TICK) ? '0 : divCnt + 1'b1;
      if (sampleNow) begin
        if (bitIdx == LAST_BIT) running <= 1'b0;
        else                    bitIdx  <= bitIdx + 1'b1;
      end
    end
  end

  // R2: every non-final capture is followed by a rising serial clock
  p_rise_after_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample && !strb.commit |=> $rose(sclkOut));

  // R2: positions advance by exactly one per capture
  p_bit_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.sample && !strb.commit |=> bitIdx == $past(bitIdx) + 1'b1);

  // R9: once stopped the loader stays stopped with the clock low
  p_stop_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    !running |=> !running && !sclkOut);

endmodule

// File: rtl/bml_datapath.sv
module bml_datapath
  import bml_pkg::*;
#(
  parameter int STREAM_LEN = 256
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ld_strobe_t                    strb,
  input  logic [$clog2(STREAM_LEN)-1:0] bitIdx,
  input  logic                          serData,
  output boot_mode_t                    modeQ,
  output logic                          errQ,
  output logic                          doneQ
);

  localparam int IDX_W = $clog2(STREAM_LEN);

  logic [CAP_W-1:0] capQ;
  logic [CAP_W-1:0] capNext;
  logic             rsvdSeen;
  logic             hiRsvd;

  function automatic logic [6:0] drivePercent(input logic [1:0] code);
    case (code)
      2'b10:   return 7'd100;
      2'b11:   return 7'd83;
      2'b00:   return 7'd67;
      default: return 7'd50;
    endcase
  endfunction

  function automatic boot_mode_t decodeMode(input logic [CAP_W-1:0] c);
    boot_mode_t m;
    m.xferPattern = c[POS_PAT +: 4];
    m.clkRatio    = {1'b0, c[POS_RATIO +: 3]} + 4'd2;
    m.bigEndian   = c[POS_ENDIAN];
    m.wrMode      = wr_mode_e'(c[POS_WRMODE +: 2]);
    m.timerIntOff = c[POS_TIMER];
    m.narrowBus   = c[POS_WIDTH];
    m.drivePct    = drivePercent(c[POS_DRIVE +: 2]);
    m.wrDataDelay = c[POS_DELAY +: 3];
    m.slowMul     = c[POS_SLOWMUL];
    return m;
  endfunction

  function automatic logic lowFieldBad(input logic [CAP_W-1:0] c);
    return c[0] | c[POS_RSVD_LO]
         | (c[POS_PAT +: 4] > 4'(PAT_MAX_OK))
         | (c[POS_RATIO +: 3] == 3'd7)
         | (c[POS_WRMODE +: 2] == WR_BAD);
  endfunction

  assign hiRsvd = (int'(bitIdx) >= POS_RSVD_HI);

  // merge the bit being captured so commit sees the complete vector
  always_comb begin
    capNext = capQ;
    if (strb.sample) begin
      for (int i = 0; i < CAP_W; i++) begin
        if (bitIdx == IDX_W'(i)) capNext[i] = serData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ     <= '0;
      rsvdSeen <= 1'b0;
      modeQ    <= MODE_DEFAULT;
      errQ     <= 1'b0;
      doneQ    <= 1'b0;
    end else if (strb.sample) begin
      capQ <= capNext;
      if (hiRsvd && serData) rsvdSeen <= 1'b1;
      if (strb.commit) begin
        modeQ <= decodeMode(capNext);
        errQ  <= rsvdSeen | (hiRsvd & serData) | lowFieldBad(capNext);
        doneQ <= 1'b1;
      end
    end
  end

  // R9: published mode and error freeze once done
  p_hold_after_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> doneQ && $stable(modeQ) && $stable(errQ));

  // R8: the error flag is only reported together with done
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    !doneQ |-> !errQ);

  // R7: done only follows the final-bit strobe
  p_done_on_commit_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> $past(strb.commit));

  // R7: reset values held while loading
  p_defaults_before_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !doneQ |-> modeQ == MODE_DEFAULT);

endmodule

// File: rtl/boot_mode_loader.sv
module boot_mode_loader
  import bml_pkg::*;
#(
  parameter int DIV        = 256,
  parameter int STREAM_LEN = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serData,
  output logic       sclkOut,
  output logic [3:0] xferPattern,
  output logic [3:0] clkRatio,
  output logic       bigEndian,
  output logic [1:0] wrMode,
  output logic       timerIntOff,
  output logic       narrowBus,
  output logic [6:0] drivePct,
  output logic [2:0] wrDataDelay,
  output logic       slowMul,
  output logic       cfgError,
  output logic       cfgDone
);

  localparam int IDX_W = $clog2(STREAM_LEN);

  ld_strobe_t       strb;
  logic [IDX_W-1:0] bitIdx;
  boot_mode_t       modeQ;

  bml_ctrl #(.DIV(DIV), .STREAM_LEN(STREAM_LEN)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bitIdx  (bitIdx),
    .sclkOut (sclkOut)
  );

  bml_datapath #(.STREAM_LEN(STREAM_LEN)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .bitIdx  (bitIdx),
    .serData (serData),
    .modeQ   (modeQ),
    .errQ    (cfgError),
    .doneQ   (cfgDone)
  );

  assign xferPattern = modeQ.xferPattern;
  assign clkRatio    = modeQ.clkRatio;
  assign bigEndian   = modeQ.bigEndian;
  assign wrMode      = modeQ.wrMode;
  assign timerIntOff = modeQ.timerIntOff;
  assign narrowBus   = modeQ.narrowBus;
  assign drivePct    = modeQ.drivePct;
  assign wrDataDelay = modeQ.wrDataDelay;
  assign slowMul     = modeQ.slowMul;

endmodule

// File: tb/sim_boot_mode_loader.sv
`timescale 1ns/1ps
module sim_boot_mode_loader;
  import bml_pkg::*;

  localparam int SLOW_DIV = 256;
  localparam int FAST_DIV = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always_ff @(posedge clk) cyc <= cyc + 1;

  logic rst0N = 1'b0;
  logic rst1N = 1'b0;
  logic serData = 1'b0;
  logic useSlow = 1'b0;

  int checks = 0;
  int errors = 0;

  // slow instance: default divider
  logic sclk0, big0, tmr0, nar0, slw0, err0, done0;
  logic [3:0] pat0, rat0;
  logic [1:0] wr0;
  logic [6:0] drv0;
  logic [2:0] dly0;

  // fast instance: short divider for the many scenarios
  logic sclk1, big1, tmr1, nar1, slw1, err1, done1;
  logic [3:0] pat1, rat1;
  logic [1:0] wr1;
  logic [6:0] drv1;
  logic [2:0] dly1;

  boot_mode_loader u0 (
    .clk(clk), .rstN(rst0N), .serData(serData), .sclkOut(sclk0),
    .xferPattern(pat0), .clkRatio(rat0), .bigEndian(big0), .wrMode(wr0),
    .timerIntOff(tmr0), .narrowBus(nar0), .drivePct(drv0), .wrDataDelay(dly0),
    .slowMul(slw0), .cfgError(err0), .cfgDone(done0)
  );

  boot_mode_loader #(.DIV(FAST_DIV)) u1 (
    .clk(clk), .rstN(rst1N), .serData(serData), .sclkOut(sclk1),
    .xferPattern(pat1), .clkRatio(rat1), .bigEndian(big1), .wrMode(wr1),
    .timerIntOff(tmr1), .narrowBus(nar1), .drivePct(drv1), .wrDataDelay(dly1),
    .slowMul(slw1), .cfgError(err1), .cfgDone(done1)
  );

  logic       sclkSel, errSel, doneSel;
  boot_mode_t obs0, obs1, obsSel;
  assign obs0 = '{pat0, rat0, big0, wr_mode_e'(wr0), tmr0, nar0, drv0, dly0, slw0};
  assign obs1 = '{pat1, rat1, big1, wr_mode_e'(wr1), tmr1, nar1, drv1, dly1, slw1};
  assign obsSel  = useSlow ? obs0 : obs1;
  assign sclkSel = useSlow ? sclk0 : sclk1;
  assign errSel  = useSlow ? err0 : err1;
  assign doneSel = useSlow ? done0 : done1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] mk(input int pat, input int rc, input int big,
      input int wr, input int tmr, input int nar, input int drv, input int dly,
      input int slw);
    logic [255:0] s = '0;
    s[4:1]   = pat[3:0];
    s[7:5]   = rc[2:0];
    s[8]     = big[0];
    s[10:9]  = wr[1:0];
    s[11]    = tmr[0];
    s[12]    = nar[0];
    s[14:13] = drv[1:0];
    s[17:15] = dly[2:0];
    s[19]    = slw[0];
    return s;
  endfunction

  function automatic int expPct(input logic [1:0] c);
    if (c == 2'b10) return 100;
    if (c == 2'b11) return 83;
    if (c == 2'b00) return 67;
    return 50;
  endfunction

  function automatic int expErr(input logic [255:0] s);
    return int'(s[0] | s[18] | (|s[255:20]) | (s[4:1] > 4'd8) |
                (s[7:5] == 3'd7) | (s[10:9] == 2'b01));
  endfunction

  task automatic checkDecoded(input string scen, input logic [255:0] s);
    chk(obsSel.xferPattern == s[4:1], "R3", {scen, " pattern"}, obsSel.xferPattern, s[4:1]);
    chk(obsSel.clkRatio == 4'(s[7:5]) + 4'd2, "R3", {scen, " ratio"},
        obsSel.clkRatio, int'(s[7:5]) + 2);
    chk({obsSel.bigEndian, obsSel.timerIntOff, obsSel.narrowBus, obsSel.slowMul} ==
        {s[8], s[11], s[12], s[19]}, "R4", {scen, " flags"},
        {obsSel.bigEndian, obsSel.timerIntOff, obsSel.narrowBus, obsSel.slowMul},
        {s[8], s[11], s[12], s[19]});
    chk(obsSel.wrMode == s[10:9], "R5", {scen, " write mode"}, obsSel.wrMode, s[10:9]);
    chk(obsSel.wrDataDelay == s[17:15], "R5", {scen, " delay"}, obsSel.wrDataDelay, s[17:15]);
    chk(int'(obsSel.drivePct) == expPct(s[14:13]), "R6", {scen, " drive"},
        obsSel.drivePct, expPct(s[14:13]));
    chk(int'(errSel) == expErr(s), "R8", {scen, " error"}, errSel, expErr(s));
  endtask

  // full load of one stream through the selected instance
  task automatic runLoad(input bit slow, input logic [255:0] s, input string scen);
    int tNeg = 0;
    int div = slow ? SLOW_DIV : FAST_DIV;
    useSlow = slow;
    rst0N = 1'b0;
    rst1N = 1'b0;
    serData = s[0];
    repeat (3) @(negedge clk);
    if (slow) rst0N = 1'b1; else rst1N = 1'b1;
    for (int k = 1; k < 256; k++) begin
      @(negedge sclkSel);
      serData = s[k];
      if (slow && k == 2) begin
        tNeg = cyc;
        @(posedge sclkSel);
        chk(cyc - tNeg == div / 2, "R1", {scen, " low time"}, cyc - tNeg, div / 2);
      end
      if (slow && k == 3)
        chk(cyc - tNeg == div, "R1", {scen, " period"}, cyc - tNeg, div);
      if (k == 128) begin
        @(negedge clk);
        chk(!doneSel && !errSel && obsSel == MODE_DEFAULT, "R7",
            {scen, " defaults mid-stream"}, doneSel, 0);
      end
      if (k == 255) begin
        @(negedge clk);
        chk(!doneSel, "R7", {scen, " not done before last bit"}, doneSel, 0);
      end
    end
    for (int w = 0; w < div + 8 && !doneSel; w++) @(negedge clk);
    chk(doneSel, "R7", {scen, " done after last bit"}, doneSel, 1);
    checkDecoded(scen, s);
  endtask

  task automatic scenReset();
    rst1N = 1'b0;
    useSlow = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sclk1 && !done1 && !err1, "R1", "clock low and flags clear in reset",
        {sclk1, done1, err1}, 0);
    chk(obs1 == MODE_DEFAULT, "R7", "reset values", obs1.clkRatio, 2);
  endtask

  task automatic scenValid();
    runLoad(1'b0, mk(5, 3, 1, 2, 0, 1, 3, 6, 1), "cfgA");
    runLoad(1'b0, mk(8, 6, 0, 3, 1, 0, 1, 7, 0), "cfgB");
    runLoad(1'b0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0), "cfgC");
    runLoad(1'b0, mk(3, 0, 1, 0, 1, 1, 2, 1, 1), "cfgD");
  endtask

  task automatic scenBadCodes();
    runLoad(1'b0, mk(9, 2, 0, 2, 0, 0, 2, 0, 0), "pattern 9");
    runLoad(1'b0, mk(15, 2, 0, 2, 0, 0, 2, 0, 0), "pattern 15");
    runLoad(1'b0, mk(1, 7, 0, 2, 0, 0, 2, 0, 0), "ratio code 7");
    runLoad(1'b0, mk(1, 2, 0, 1, 0, 0, 2, 0, 0), "write mode 01");
  endtask

  task automatic scenBadBits();
    logic [255:0] base = mk(2, 1, 0, 3, 0, 0, 2, 2, 0);
    logic [255:0] s;
    s = base; s[0] = 1'b1;   runLoad(1'b0, s, "bit 0 set");
    s = base; s[18] = 1'b1;  runLoad(1'b0, s, "bit 18 set");
    s = base; s[25] = 1'b1;  runLoad(1'b0, s, "bit 25 set");
    s = base; s[255] = 1'b1; runLoad(1'b0, s, "bit 255 set");
  endtask

  task automatic scenAfterDone();
    logic [255:0] s = mk(6, 4, 1, 2, 1, 0, 3, 5, 1);
    boot_mode_t held;
    logic heldErr;
    bit clkQuiet = 1'b1;
    runLoad(1'b0, s, "post-done");
    held = obs1;
    heldErr = err1;
    for (int i = 0; i < 16 * FAST_DIV; i++) begin
      serData = ~serData;
      @(negedge clk);
      if (sclk1) clkQuiet = 1'b0;
    end
    chk(clkQuiet, "R9", "serial clock held low after done", clkQuiet, 1);
    chk(obs1 == held && err1 == heldErr && done1, "R9", "outputs frozen after done",
        obs1.xferPattern, held.xferPattern);
  endtask

  task automatic scenSlow();
    runLoad(1'b1, mk(7, 5, 1, 3, 0, 1, 0, 3, 1), "default divider");
  endtask

  initial begin
    scenReset();
    scenValid();
    scenBadCodes();
    scenBadBits();
    scenAfterDone();
    scenSlow();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule